// File: doc/BRIEF.md
# Lookup Table Row Selector

This block keeps two 64-byte lookup tables. For each table it forms the memory byte address of the active row and reads the byte stored there. That byte, or a value held in a register, becomes the input byte of one of two digital-to-analog converters.

A table's row index comes from one of two places, chosen per table. It is either the upper six bits of the filtered 8-bit converter code or a 6-bit manual row field. The block adds a fixed base address for each table to that index. Each converter input can also skip its table and take a directly supplied byte instead.

The tables are loaded through a byte write port that uses valid/ready. A write is accepted in every cycle in which `wr_valid` and `wr_ready` are both high. `wr_ready` is low while reset is asserted and high from the first clock edge after reset is released, so outside reset the block applies no back-pressure. A source that holds `wr_valid` during reset keeps its data until `wr_ready` rises.

Top module: `lut_row_sel`

## Requirements
- R1: The address of table 0 is 0x090 plus its 6-bit row index. The address of table 1 is 0x0D0 plus its row index. Both are 9 bits wide and never wrap, so they lie in 0x090..0x0CF and 0x0D0..0x10F.
- R2: When bit k of `tbl_direct` is 0, the row index of table k is `conv_code[7:2]`.
- R3: When bit k of `tbl_direct` is 1, the row index of table k is `man_row_k`, and `conv_code` has no effect on that table's address or its converter byte.
- R4: When bit k of `dac_direct` is 0, `dac_out_k` takes the byte in the selected row of table k. The output is registered and shows a new row selection one clock edge after the input changes.
- R5: When bit k of `dac_direct` is 1, `dac_out_k` takes `dac_val_k` one clock edge later, whatever the table holds or selects.
- R6: An accepted write whose address lies in a table's window stores `wr_data` at row (address − base). When that row is selected, the new byte reaches the converter output by the second clock edge after the write edge.
- R7: An accepted write to an address outside both windows (0x000..0x08F or 0x110..0x1FF) changes no table byte.
- R8: While `rst` is high, both converter outputs are 0x00, every table byte is cleared to 0x00 and `wr_ready` is low.
- R9: If the inputs are held and no write is accepted, both converter outputs stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| conv_code | input | 8 | Filtered converter code; bits 7:2 are the default row index |
| tbl_direct | input | 2 | Per-table row source: 0 = converter code, 1 = manual field |
| man_row0 | input | 6 | Manual row index for table 0 |
| man_row1 | input | 6 | Manual row index for table 1 |
| dac_direct | input | 2 | Per-converter source: 0 = table byte, 1 = direct value |
| dac_val0 | input | 8 | Direct byte for converter 0 |
| dac_val1 | input | 8 | Direct byte for converter 1 |
| wr_valid | input | 1 | Table write request |
| wr_ready | output | 1 | Write port ready; low during reset |
| wr_addr | input | 9 | Table write byte address |
| wr_data | input | 8 | Table write byte |
| tbl_addr0 | output | 9 | Address of the active row of table 0 |
| tbl_addr1 | output | 9 | Address of the active row of table 1 |
| dac_out0 | output | 8 | Registered input byte for converter 0 |
| dac_out1 | output | 8 | Registered input byte for converter 1 |

## Verification
Each table is first filled with its own arithmetic pattern, so every row holds a different byte and the two tables differ at every row. The converter code is then swept through all 256 values. This separates the use of the upper six bits from any use of the low two, and it catches a swapped base or a swapped table. The manual rows are swept with the two tables moving in opposite directions while the converter code runs on unrelated values, which shows that the code is ignored. All 256 direct bytes are also tried against a moving table row. Writes to the first and last row of each window, and to the addresses just outside each window, are then checked by reading every row back through the converter outputs.

// File: rtl/lrs_pkg.sv
package lrs_pkg;
  // Where a table's row index comes from.
  typedef enum logic {
    ROW_FROM_CODE = 1'b0,
    ROW_FROM_MAN  = 1'b1
  } row_src_e;

  // What drives a converter input byte.
  typedef enum logic {
    DAC_FROM_TABLE = 1'b0,
    DAC_FROM_REG   = 1'b1
  } dac_src_e;
endpackage

// File: rtl/lrs_row_mux.sv
module lrs_row_mux
  import lrs_pkg::*;
#(
  parameter int unsigned ROW_W  = 6,
  parameter int unsigned ADDR_W = 9,
  parameter logic [ADDR_W-1:0] BASE = 9'h090
) (
  input  logic [ROW_W-1:0]  code_row,
  input  logic [ROW_W-1:0]  man_row,
  input  row_src_e          src,
  output logic [ROW_W-1:0]  row,
  output logic [ADDR_W-1:0] addr
);
  localparam int unsigned PAD_W = ADDR_W - ROW_W;

  always_comb begin
    row  = (src == ROW_FROM_MAN) ? man_row : code_row;
    addr = BASE + {{PAD_W{1'b0}}, row};
  end
endmodule

// File: rtl/lrs_table_bank.sv
module lrs_table_bank #(
  parameter int unsigned ROW_W  = 6,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 9,
  parameter logic [ADDR_W-1:0] BASE = 9'h090
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ROW_W-1:0]  rd_row,
  output logic [DATA_W-1:0] rd_data
);
  localparam int unsigned DEPTH = 1 << ROW_W;
  // Window bounds carried one bit wider so the top of a window never wraps.
  localparam logic [ADDR_W:0] LO = {1'b0, BASE};
  localparam logic [ADDR_W:0] HI = LO + (ADDR_W+1)'(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic              hit;
  logic [ADDR_W-1:0] offs;
  logic [ROW_W-1:0]  wr_row;
  logic              unused_offs;

  always_comb begin
    hit    = ({1'b0, wr_addr} >= LO) && ({1'b0, wr_addr} < HI);
    offs   = wr_addr - BASE;
    wr_row = offs[ROW_W-1:0];
  end
  assign unused_offs = ^offs[ADDR_W-1:ROW_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en && hit) begin
      mem[wr_row] <= wr_data;
    end
  end

  assign rd_data = mem[rd_row];
endmodule

// File: rtl/lrs_dac_src.sv
module lrs_dac_src
  import lrs_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  dac_src_e          src,
  input  logic [DATA_W-1:0] tbl_byte,
  input  logic [DATA_W-1:0] reg_byte,
  output logic [DATA_W-1:0] dac_q
);
  logic [DATA_W-1:0] dac_d;

  always_comb dac_d = (src == DAC_FROM_REG) ? reg_byte : tbl_byte;

  always_ff @(posedge clk) begin
    if (rst) dac_q <= '0;
    else     dac_q <= dac_d;
  end
endmodule

// File: rtl/lut_row_sel.sv
module lut_row_sel
  import lrs_pkg::*;
#(
  parameter int unsigned CODE_W = 8,
  parameter int unsigned ROW_W  = 6,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 9,
  parameter logic [ADDR_W-1:0] BASE_A = 9'h090,
  parameter logic [ADDR_W-1:0] BASE_B = 9'h0D0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] conv_code,
  input  logic [1:0]        tbl_direct,
  input  logic [ROW_W-1:0]  man_row0,
  input  logic [ROW_W-1:0]  man_row1,
  input  logic [1:0]        dac_direct,
  input  logic [DATA_W-1:0] dac_val0,
  input  logic [DATA_W-1:0] dac_val1,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [ADDR_W-1:0] tbl_addr0,
  output logic [ADDR_W-1:0] tbl_addr1,
  output logic [DATA_W-1:0] dac_out0,
  output logic [DATA_W-1:0] dac_out1
);
  localparam int unsigned NTBL  = 2;
  localparam int unsigned LOW_W = CODE_W - ROW_W;

  logic [ROW_W-1:0]  code_row;
  logic              unused_low;
  logic              rdy_q;
  logic              wr_fire;

  logic [ROW_W-1:0]  man_v  [NTBL];
  logic [DATA_W-1:0] val_v  [NTBL];
  logic [ROW_W-1:0]  row_v  [NTBL];
  logic [ADDR_W-1:0] addr_v [NTBL];
  logic [DATA_W-1:0] byte_v [NTBL];
  logic [DATA_W-1:0] out_v  [NTBL];

  // The upper bits of the code pick the row; the low bits carry no row weight.
  assign code_row   = conv_code[CODE_W-1 -: ROW_W];
  assign unused_low = ^conv_code[LOW_W-1:0];

  // The write port is ready from the first edge after reset is released.
  always_ff @(posedge clk) begin
    if (rst) rdy_q <= 1'b0;
    else     rdy_q <= 1'b1;
  end
  assign wr_ready = rdy_q;
  assign wr_fire  = wr_valid && rdy_q;

  assign man_v[0] = man_row0;
  assign man_v[1] = man_row1;
  assign val_v[0] = dac_val0;
  assign val_v[1] = dac_val1;

  for (genvar k = 0; k < NTBL; k++) begin : g_tbl
    localparam logic [ADDR_W-1:0] BASE_K = (k == 0) ? BASE_A : BASE_B;

    lrs_row_mux #(
      .ROW_W (ROW_W),
      .ADDR_W(ADDR_W),
      .BASE  (BASE_K)
    ) row_i (
      .code_row(code_row),
      .man_row (man_v[k]),
      .src     (row_src_e'(tbl_direct[k])),
      .row     (row_v[k]),
      .addr    (addr_v[k])
    );

    lrs_table_bank #(
      .ROW_W (ROW_W),
      .DATA_W(DATA_W),
      .ADDR_W(ADDR_W),
      .BASE  (BASE_K)
    ) bank_i (
      .clk    (clk),
      .rst    (rst),
      .wr_en  (wr_fire),
      .wr_addr(wr_addr),
      .wr_data(wr_data),
      .rd_row (row_v[k]),
      .rd_data(byte_v[k])
    );

    lrs_dac_src #(
      .DATA_W(DATA_W)
    ) dac_i (
      .clk     (clk),
      .rst     (rst),
      .src     (dac_src_e'(dac_direct[k])),
      .tbl_byte(byte_v[k]),
      .reg_byte(val_v[k]),
      .dac_q   (out_v[k])
    );
  end

  assign tbl_addr0 = addr_v[0];
  assign tbl_addr1 = addr_v[1];
  assign dac_out0  = out_v[0];
  assign dac_out1  = out_v[1];
endmodule

// File: rtl/lrs_chk.sv
module lrs_chk #(
  parameter int unsigned CODE_W = 8,
  parameter int unsigned ROW_W  = 6,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 9,
  parameter logic [ADDR_W-1:0] BASE_A = 9'h090,
  parameter logic [ADDR_W-1:0] BASE_B = 9'h0D0
) (
  input logic              clk,
  input logic              rst,
  input logic [CODE_W-1:0] conv_code,
  input logic [1:0]        tbl_direct,
  input logic [ROW_W-1:0]  man_row0,
  input logic [ROW_W-1:0]  man_row1,
  input logic [1:0]        dac_direct,
  input logic [DATA_W-1:0] dac_val0,
  input logic [DATA_W-1:0] dac_val1,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [ADDR_W-1:0] tbl_addr0,
  input logic [ADDR_W-1:0] tbl_addr1,
  input logic [DATA_W-1:0] dac_out0,
  input logic [DATA_W-1:0] dac_out1
);
  localparam int unsigned PAD_W = ADDR_W - ROW_W;
  localparam logic [ADDR_W-1:0] TOP_A = BASE_A + ADDR_W'((1 << ROW_W) - 1);
  localparam logic [ADDR_W-1:0] TOP_B = BASE_B + ADDR_W'((1 << ROW_W) - 1);

  logic [ADDR_W-1:0] code_ext;
  logic [ADDR_W-1:0] man0_ext;
  logic [ADDR_W-1:0] man1_ext;
  logic              fire;

  assign code_ext = {{PAD_W{1'b0}}, conv_code[CODE_W-1 -: ROW_W]};
  assign man0_ext = {{PAD_W{1'b0}}, man_row0};
  assign man1_ext = {{PAD_W{1'b0}}, man_row1};
  assign fire     = wr_valid && wr_ready;

  // R1: each address stays inside its own table window.
  p_addr_window_r1: assert property (@(posedge clk) disable iff (rst)
    (tbl_addr0 >= BASE_A) && (tbl_addr0 <= TOP_A) &&
    (tbl_addr1 >= BASE_B) && (tbl_addr1 <= TOP_B));

  // R2: the code drives the row when the direct-access bit is clear.
  p_addr_code_r2: assert property (@(posedge clk) disable iff (rst)
    !tbl_direct[1] |-> (tbl_addr1 == BASE_B + code_ext));

  // R3: the manual field drives the row when the direct-access bit is set.
  p_addr_man_r3: assert property (@(posedge clk) disable iff (rst)
    tbl_direct[0] |-> (tbl_addr0 == BASE_A + man0_ext));

  p_addr_man1_r3: assert property (@(posedge clk) disable iff (rst)
    tbl_direct[1] |-> (tbl_addr1 == BASE_B + man1_ext));

  // R5: the direct byte reaches the output one edge later.
  p_dac_reg0_r5: assert property (@(posedge clk) disable iff (rst)
    dac_direct[0] |=> (dac_out0 == $past(dac_val0)));

  p_dac_reg1_r5: assert property (@(posedge clk) disable iff (rst)
    dac_direct[1] |=> (dac_out1 == $past(dac_val1)));

  // R8: reset clears the outputs and holds the write port off.
  p_reset_clear_r8: assert property (@(posedge clk)
    rst |=> ((dac_out0 == '0) && (dac_out1 == '0) && !wr_ready));

  // R9: held inputs and no recent write keep the outputs steady.
  p_steady_out_r9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(fire) &&
     $stable({conv_code, tbl_direct, man_row0, man_row1,
              dac_direct, dac_val0, dac_val1}))
    |=> ($stable(dac_out0) && $stable(dac_out1)));
endmodule

bind lut_row_sel lrs_chk #(
  .CODE_W(CODE_W),
  .ROW_W (ROW_W),
  .DATA_W(DATA_W),
  .ADDR_W(ADDR_W),
  .BASE_A(BASE_A),
  .BASE_B(BASE_B)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .conv_code (conv_code),
  .tbl_direct(tbl_direct),
  .man_row0  (man_row0),
  .man_row1  (man_row1),
  .dac_direct(dac_direct),
  .dac_val0  (dac_val0),
  .dac_val1  (dac_val1),
  .wr_valid  (wr_valid),
  .wr_ready  (wr_ready),
  .tbl_addr0 (tbl_addr0),
  .tbl_addr1 (tbl_addr1),
  .dac_out0  (dac_out0),
  .dac_out1  (dac_out1)
);

// File: tb/lut_row_sel_tb_top.sv
`timescale 1ns/1ps
module lut_row_sel_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] conv_code = '0;
  logic [1:0] tbl_direct = '0;
  logic [5:0] man_row0 = '0, man_row1 = '0;
  logic [1:0] dac_direct = '0;
  logic [7:0] dac_val0 = '0, dac_val1 = '0;
  logic       wr_valid = 1'b0;
  logic       wr_ready;
  logic [8:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [8:0] tbl_addr0, tbl_addr1;
  logic [7:0] dac_out0, dac_out1;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [7:0] model [2][64];

  always #5 clk = ~clk;

  lut_row_sel dut_i (
    .clk(clk), .rst(rst), .conv_code(conv_code), .tbl_direct(tbl_direct),
    .man_row0(man_row0), .man_row1(man_row1), .dac_direct(dac_direct),
    .dac_val0(dac_val0), .dac_val1(dac_val1), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .tbl_addr0(tbl_addr0), .tbl_addr1(tbl_addr1),
    .dac_out0(dac_out0), .dac_out1(dac_out1)
  );

  function automatic logic [8:0] base_of(int t);
    return (t == 0) ? 9'h090 : 9'h0D0;
  endfunction

  function automatic logic [7:0] pat(int t, int r);
    return 8'((r * 7) + (t * 8'h55) + 3);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // One accepted write; the bench model follows the window rule of R6/R7.
  task automatic write(input logic [8:0] a, input logic [7:0] d);
    wr_valid = 1'b1;
    wr_addr  = a;
    wr_data  = d;
    step();
    wr_valid = 1'b0;
    for (int t = 0; t < 2; t++) begin
      if (a >= base_of(t) && a < base_of(t) + 9'd64)
        model[t][a - base_of(t)] = d;
    end
  endtask

  task automatic check_outs(input string req, input logic [7:0] e0, input logic [7:0] e1);
    chk(dac_out0 == e0, req, dac_out0, e0);
    chk(dac_out1 == e1, req, dac_out1, e1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int t = 0; t < 2; t++)
      for (int r = 0; r < 64; r++) model[t][r] = 8'h00;

    // R8: reset state
    @(negedge clk);
    step();
    check_outs("R8 reset outputs", 8'h00, 8'h00);
    chk(wr_ready == 1'b0, "R8 ready low in reset", wr_ready, 0);
    rst = 1'b0;
    step();
    chk(wr_ready == 1'b1, "R8 ready after reset", wr_ready, 1);
    check_outs("R8 table cleared", 8'h00, 8'h00);

    // R6: preload every row of both tables
    for (int t = 0; t < 2; t++)
      for (int r = 0; r < 64; r++) write(base_of(t) + 9'(r), pat(t, r));

    // R1 R2 R4: converter code sweep
    tbl_direct = 2'b00;
    dac_direct = 2'b00;
    for (int c = 0; c < 256; c++) begin
      conv_code = 8'(c);
      #1;
      chk(tbl_addr0 == 9'h090 + 9'(c >> 2), "R2 code address t0", tbl_addr0, 9'h090 + 9'(c >> 2));
      chk(tbl_addr1 == 9'h0D0 + 9'(c >> 2), "R1 code address t1", tbl_addr1, 9'h0D0 + 9'(c >> 2));
      step();
      check_outs("R4 table byte by code", model[0][c >> 2], model[1][c >> 2]);
    end

    // R3: manual rows, converter code moving underneath
    tbl_direct = 2'b11;
    for (int r = 0; r < 64; r++) begin
      man_row0  = 6'(r);
      man_row1  = 6'(63 - r);
      conv_code = 8'((r * 37) + 11);
      #1;
      chk(tbl_addr0 == 9'h090 + 9'(r), "R3 manual address t0", tbl_addr0, 9'h090 + 9'(r));
      chk(tbl_addr1 == 9'h0D0 + 9'(63 - r), "R3 manual address t1", tbl_addr1, 9'h0D0 + 9'(63 - r));
      step();
      check_outs("R3 manual row byte", model[0][r], model[1][63 - r]);
    end

    // R2 R3: mixed selection per table
    tbl_direct = 2'b01;
    man_row0   = 6'd9;
    conv_code  = 8'hB7;
    step();
    check_outs("R2 mixed selection", model[0][9], model[1][8'hB7 >> 2]);

    // R9: held inputs keep outputs
    repeat (3) begin
      step();
      check_outs("R9 steady outputs", model[0][9], model[1][8'hB7 >> 2]);
    end

    // R5: direct bytes, table row still moving
    dac_direct = 2'b11;
    tbl_direct = 2'b11;
    for (int v = 0; v < 256; v++) begin
      dac_val0 = 8'(v);
      dac_val1 = 8'(255 - v);
      man_row0 = 6'(v);
      man_row1 = 6'(v + 17);
      step();
      check_outs("R5 direct byte", 8'(v), 8'(255 - v));
    end

    // R6: writes at window edges reach the selected row's output
    dac_direct = 2'b00;
    man_row0 = 6'd63;
    man_row1 = 6'd0;
    write(9'h0CF, 8'hA7);
    write(9'h0D0, 8'h3C);
    step();
    check_outs("R6 edge rows write", 8'hA7, 8'h3C);
    man_row0 = 6'd5;
    man_row1 = 6'd60;
    step();
    write(9'h095, 8'h5A);
    step();
    check_outs("R6 write visible in two cycles t0", 8'h5A, model[1][60]);
    write(9'h10C, 8'hC3);
    step();
    check_outs("R6 write visible in two cycles t1", 8'h5A, 8'hC3);

    // R7: writes outside both windows change no row
    write(9'h08F, 8'hEE);
    write(9'h000, 8'hEE);
    write(9'h110, 8'hEE);
    write(9'h1FF, 8'hEE);
    for (int r = 0; r < 64; r++) begin
      man_row0 = 6'(r);
      man_row1 = 6'(r);
      step();
      check_outs("R7 out-of-window writes ignored", model[0][r], model[1][r]);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule